// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block holds the current time and date as eight packed-BCD registers: seconds, minutes, hours, date of month, month, day of week, year within the century, and century. A single-cycle pulse on `tick_i`, normally produced once per second by an external prescaler, advances the seconds register. Any carry it produces travels through every field in that same clock cycle. Hours count either on a 24-hour dial or on a 12-hour dial with a PM flag. Bit 7 of the hours register selects the dial. The date wraps according to the month's length and to leap years. When the year wraps, the century advances.

A host interface writes a complete time image in parallel through `load_i` and `load_data_i`. Every register is presented continuously on its own output. A write-protect flag travels with each load. While the flag is set, further loads change nothing except the flag itself.

Top module: `bcd_calendar`

## Requirements
- R1: While `rst` is high the registers take these values: seconds 00h, minutes 00h, hours 00h (24-hour mode, hour 00), date 01h, month 01h, day of week 01h, year 00h, century 19h, and `wp_o` 0.
- R2: Each effective tick increments seconds in BCD. 59 is followed by 00, and at that wrap minutes increment, with 59 followed by 00. The whole carry completes on a single tick, so 13:59:59 becomes 14:00:00.
- R3: When hours bit 7 is 0 (24-hour mode), bits 5:0 hold BCD 00 to 23. 23 is followed by 00, and that step advances the date.
- R4: When hours bit 7 is 1 (12-hour mode), bit 5 is the PM flag, bit 6 reads 0, and bits 4:0 hold BCD 01 to 12. Going from 11 to 12 toggles the PM flag. Going from 12 to 01 keeps it. Going from 11 PM to 12 AM advances the date. The mode bit never changes except by a load.
- R5: Each month has a last date: 30 for months 04h, 06h, 09h and 11h, 31 for the other months except February, and 28 or 29 for month 02h. When the date steps past the last date it becomes 01h and the month advances; otherwise the date only increments.
- R6: A year whose BCD value is divisible by 4, including 00, is a leap year: February ends at 29 in a leap year and at 28 otherwise.
- R7: Month 12h is followed by 01h and that step advances the year. Year 99h is followed by 00h and that step advances the century. Century 99h is followed by 00h.
- R8: The day of week advances once for every date advance, running 1 through 7 and then back to 1.
- R9: On a cycle with neither `tick_i` nor `load_i`, no register changes.
- R10: `load_i` high with `wp_o` low copies `load_data_i` into the registers. The register outputs show the new value one cycle later. The byte layout of `load_data_i` is: bits 7:0 seconds, 15:8 minutes, 23:16 hours, 31:24 date, 39:32 month, 47:40 day of week, 55:48 year, 63:56 century. A tick in the same cycle as such a load is discarded, and the next tick advances from the loaded time.
- R11: Every load copies `load_wp_i` into `wp_o`. A load made while `wp_o` is 1 leaves all time fields unchanged. A tick in that same cycle still advances the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse that advances the time by one second |
| load_i | input | 1 | Parallel load strobe |
| load_data_i | input | 64 | Packed BCD time image to load |
| load_wp_i | input | 1 | Write-protect value captured on every load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode bit and PM/20-hour bit |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| dow_o | output | 8 | Day of week, BCD 1 to 7 |
| year_o | output | 8 | Year within the century, BCD |
| century_o | output | 8 | Century, BCD |
| wp_o | output | 1 | Write-protect flag |

## Verification
Directed loads place the clock just before each carry boundary:
- a full minute-and-hour ripple;
- the end of a 30-day month;
- the end of February in common and leap years, including year 00;
- the end of December at year 99 and century 99;
- the three distinct 12-hour transitions.

Each case separates a correct carry from a carry that stops one field too early or wraps at the wrong value. Random loads of valid times are biased toward end-of-field values and followed by runs of ticks with gaps. These runs compare every register against an arithmetic model and catch errors in how the carries combine. Dedicated cases cover idle cycles, a load coinciding with a tick, and protected loads with and without a tick. They tell load priority apart from tick priority and show that the protect flag blocks the time fields only.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int FW       = 8;
  localparam int NFIELDS  = 8;
  localparam int LOAD_W   = FW * NFIELDS;

  typedef struct packed {
    logic [FW-1:0] century;
    logic [FW-1:0] year;
    logic [FW-1:0] dow;
    logic [FW-1:0] month;
    logic [FW-1:0] date;
    logic [FW-1:0] hour;
    logic [FW-1:0] min;
    logic [FW-1:0] sec;
  } cal_t;

  // Two-digit BCD increment without wrap handling.
  function automatic logic [FW-1:0] bcd_inc(logic [FW-1:0] v);
    logic [FW-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisibility by four of a two-digit BCD value.
  function automatic logic bcd_div4(logic [FW-1:0] y);
    logic [3:0] u;
    u = y[3:0];
    if (y[4]) return (u == 4'd2) || (u == 4'd6);
    else      return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  function automatic logic [FW-1:0] last_date(logic [FW-1:0] mon, logic leap);
    logic [FW-1:0] r;
    case (mon)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcd_wrap_cnt.sv
module bcd_wrap_cnt
  import rtc_cal_pkg::*;
#(
  parameter logic [FW-1:0] FIRST   = 8'h00,
  parameter logic [FW-1:0] RST_VAL = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [FW-1:0] load_val_i,
  input  logic          inc_i,
  input  logic [FW-1:0] last_i,
  output logic [FW-1:0] q_o,
  output logic          wrap_o
);

  logic at_end;

  assign at_end = (q_o >= last_i);
  assign wrap_o = inc_i && at_end;

  always_ff @(posedge clk) begin
    if (rst)         q_o <= RST_VAL;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= at_end ? FIRST : bcd_inc(q_o);
  end

endmodule

// File: rtl/bcd_hour_cnt.sv
module bcd_hour_cnt
  import rtc_cal_pkg::*;
#(
  parameter logic [FW-1:0] RST_VAL = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [FW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [FW-1:0] q_o,
  output logic          day_o
);

  logic [FW-1:0] h12, h24, inc12, nxt;
  logic          pm, day_edge;

  always_comb begin
    h12      = {3'b000, q_o[4:0]};
    h24      = {2'b00, q_o[5:0]};
    pm       = q_o[5];
    inc12    = bcd_inc(h12);
    nxt      = q_o;
    day_edge = 1'b0;
    if (q_o[7]) begin
      if (h12 >= 8'h12)      nxt = {2'b10, pm, 5'h01};
      else if (h12 == 8'h11) nxt = {2'b10, ~pm, 5'h12};
      else                   nxt = {2'b10, pm, inc12[4:0]};
      day_edge = pm && (h12 == 8'h11);
    end else begin
      if (h24 >= 8'h23) nxt = 8'h00;
      else              nxt = bcd_inc(h24);
      day_edge = (h24 >= 8'h23);
    end
  end

  assign day_o = inc_i && day_edge;

  always_ff @(posedge clk) begin
    if (rst)         q_o <= RST_VAL;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= nxt;
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter logic [FW-1:0] RST_SEC     = 8'h00,
  parameter logic [FW-1:0] RST_MIN     = 8'h00,
  parameter logic [FW-1:0] RST_HOUR    = 8'h00,
  parameter logic [FW-1:0] RST_DATE    = 8'h01,
  parameter logic [FW-1:0] RST_MONTH   = 8'h01,
  parameter logic [FW-1:0] RST_DOW     = 8'h01,
  parameter logic [FW-1:0] RST_YEAR    = 8'h00,
  parameter logic [FW-1:0] RST_CENTURY = 8'h19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [LOAD_W-1:0] load_data_i,
  input  logic              load_wp_i,
  output logic [FW-1:0]     sec_o,
  output logic [FW-1:0]     min_o,
  output logic [FW-1:0]     hour_o,
  output logic [FW-1:0]     date_o,
  output logic [FW-1:0]     month_o,
  output logic [FW-1:0]     dow_o,
  output logic [FW-1:0]     year_o,
  output logic [FW-1:0]     century_o,
  output logic              wp_o
);

  cal_t          ld;
  logic          wp_q, load_en, tick_en;
  logic          c_min, c_hour, c_day, c_month, c_year, c_cent, c_none;
  logic          c_dow_unused;
  logic [FW-1:0] date_last;

  assign ld      = cal_t'(load_data_i);
  assign load_en = load_i && !wp_q;
  assign tick_en = tick_i && !load_en;

  always_ff @(posedge clk) begin
    if (rst)         wp_q <= 1'b0;
    else if (load_i) wp_q <= load_wp_i;
  end
  assign wp_o = wp_q;

  assign date_last = last_date(month_o, bcd_div4(year_o));

  bcd_wrap_cnt #(.FIRST(8'h00), .RST_VAL(RST_SEC)) u_sec (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.sec),
    .inc_i(tick_en), .last_i(8'h59), .q_o(sec_o), .wrap_o(c_min));

  bcd_wrap_cnt #(.FIRST(8'h00), .RST_VAL(RST_MIN)) u_min (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.min),
    .inc_i(c_min), .last_i(8'h59), .q_o(min_o), .wrap_o(c_hour));

  bcd_hour_cnt #(.RST_VAL(RST_HOUR)) u_hour (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.hour),
    .inc_i(c_hour), .q_o(hour_o), .day_o(c_day));

  bcd_wrap_cnt #(.FIRST(8'h01), .RST_VAL(RST_DATE)) u_date (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.date),
    .inc_i(c_day), .last_i(date_last), .q_o(date_o), .wrap_o(c_month));

  bcd_wrap_cnt #(.FIRST(8'h01), .RST_VAL(RST_DOW)) u_dow (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.dow),
    .inc_i(c_day), .last_i(8'h07), .q_o(dow_o), .wrap_o(c_dow_unused));

  bcd_wrap_cnt #(.FIRST(8'h01), .RST_VAL(RST_MONTH)) u_month (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.month),
    .inc_i(c_month), .last_i(8'h12), .q_o(month_o), .wrap_o(c_year));

  bcd_wrap_cnt #(.FIRST(8'h00), .RST_VAL(RST_YEAR)) u_year (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.year),
    .inc_i(c_year), .last_i(8'h99), .q_o(year_o), .wrap_o(c_cent));

  bcd_wrap_cnt #(.FIRST(8'h00), .RST_VAL(RST_CENTURY)) u_cent (
    .clk(clk), .rst(rst), .load_i(load_en), .load_val_i(ld.century),
    .inc_i(c_cent), .last_i(8'h99), .q_o(century_o), .wrap_o(c_none));

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick_i,
  input logic        load_i,
  input logic [63:0] load_data_i,
  input logic        load_wp_i,
  input logic [7:0]  sec_o,
  input logic [7:0]  min_o,
  input logic [7:0]  hour_o,
  input logic [7:0]  date_o,
  input logic [7:0]  month_o,
  input logic [7:0]  dow_o,
  input logic [7:0]  year_o,
  input logic [7:0]  century_o,
  input logic        wp_o
);

  logic quiet;
  assign quiet = !tick_i && !load_i;

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    quiet |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
               $stable(date_o) && $stable(month_o) && $stable(dow_o) &&
               $stable(year_o) && $stable(century_o) && $stable(wp_o)));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && sec_o == 8'h59) |=> (sec_o == 8'h00));

  a_r2_min_ripple: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && sec_o == 8'h59 && min_o == 8'h59) |=> (min_o == 8'h00));

  a_r4_mode_kept: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (hour_o[7] == $past(hour_o[7])));

  a_r7_century_only_on_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !(tick_i && year_o == 8'h99)) |=> $stable(century_o));

  a_r10_load_copies: assert property (@(posedge clk) disable iff (rst)
    (load_i && !wp_o) |=> (sec_o == $past(load_data_i[7:0]) &&
                           hour_o == $past(load_data_i[23:16]) &&
                           century_o == $past(load_data_i[63:56])));

  a_r11_wp_follows: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (wp_o == $past(load_wp_i)));

  a_r11_protected_load: assert property (@(posedge clk) disable iff (rst)
    (load_i && wp_o && !tick_i) |=> ($stable(sec_o) && $stable(min_o) &&
                                     $stable(hour_o) && $stable(date_o) &&
                                     $stable(century_o)));

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
  .load_data_i(load_data_i), .load_wp_i(load_wp_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
  .month_o(month_o), .dow_o(dow_o), .year_o(year_o),
  .century_o(century_o), .wp_o(wp_o));

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] load_data_i = '0;
  logic        load_wp_i = 1'b0;
  logic [7:0]  sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o, century_o;
  logic        wp_o;

  always #5 clk = ~clk;

  bcd_calendar dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
    .load_data_i(load_data_i), .load_wp_i(load_wp_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .dow_o(dow_o), .year_o(year_o),
    .century_o(century_o), .wp_o(wp_o));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state (binary)
  int m_s = 0, m_m = 0, m_h = 0, m_pm = 0, m_mode = 0, m_d = 1, m_mo = 1;
  int m_dow = 1, m_y = 0, m_c = 19, m_wp = 0;
  // pending load image
  int p_s, p_m, p_h, p_pm, p_mode, p_d, p_mo, p_dow, p_y, p_c;

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_enc(int mode, int pm, int h);
    if (mode != 0) return 8'h80 | (pm != 0 ? 8'h20 : 8'h00) | bcd(h);
    return bcd(h);
  endfunction

  function automatic logic [64:0] expected();
    return {m_wp[0], bcd(m_c), bcd(m_y), bcd(m_dow), bcd(m_mo), bcd(m_d),
            hour_enc(m_mode, m_pm, m_h), bcd(m_m), bcd(m_s)};
  endfunction

  task automatic model_tick();
    int day;
    day = 0;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0;
        if (m_mode != 0) begin
          if (m_h == 11) begin day = m_pm; m_h = 12; m_pm = 1 - m_pm; end
          else if (m_h == 12) m_h = 1;
          else m_h++;
        end else begin
          if (m_h == 23) begin m_h = 0; day = 1; end
          else m_h++;
        end
      end
    end
    if (day != 0) begin
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      m_d++;
      if (m_d > mlen(m_mo, m_y)) begin
        m_d = 1; m_mo++;
        if (m_mo == 13) begin
          m_mo = 1; m_y++;
          if (m_y == 100) begin m_y = 0; m_c = (m_c + 1) % 100; end
        end
      end
    end
  endtask

  task automatic set_time(int mode, int pm, int h, int mi, int s, int d, int mo,
                          int dw, int y, int c);
    p_mode = mode; p_pm = pm; p_h = h; p_m = mi; p_s = s; p_d = d;
    p_mo = mo; p_dow = dw; p_y = y; p_c = c;
    load_data_i = {bcd(c), bcd(y), bcd(dw), bcd(mo), bcd(d),
                   hour_enc(mode, pm, h), bcd(mi), bcd(s)};
  endtask

  task automatic check(string tag);
    logic [64:0] act, exp;
    act = {wp_o, century_o, year_o, dow_o, month_o, date_o, hour_o, min_o, sec_o};
    exp = expected();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives, waits one edge, updates model, checks at next negedge
  task automatic step(bit tk, bit ld, bit wp, string tag);
    bit accepted;
    tick_i = tk; load_i = ld; load_wp_i = wp;
    @(posedge clk);
    accepted = ld && (m_wp == 0);
    if (accepted) begin
      m_s = p_s; m_m = p_m; m_h = p_h; m_pm = p_pm; m_mode = p_mode;
      m_d = p_d; m_mo = p_mo; m_dow = p_dow; m_y = p_y; m_c = p_c;
    end
    if (ld) m_wp = wp;
    if (tk && !accepted) model_tick();
    @(negedge clk);
    tick_i = 1'b0; load_i = 1'b0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset values");
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release");

    // R10 load and R2 full ripple
    set_time(0, 0, 13, 59, 59, 15, 6, 3, 24, 20);
    step(0, 1, 0, "R10 load visible");
    step(1, 0, 0, "R2 13:59:59 ripple");

    // R9 idle
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R9 idle hold");

    // R10 load with coincident tick
    set_time(0, 0, 8, 30, 10, 2, 3, 2, 50, 20);
    step(1, 1, 0, "R10 tick dropped on load");
    step(1, 0, 0, "R10 advance from loaded");

    // R3 R5 R8 end of 30-day month with dow 7
    set_time(0, 0, 23, 59, 59, 30, 4, 7, 19, 20);
    step(0, 1, 0, "R10 load");
    step(1, 0, 0, "R3 R5 R8 Apr 30 rollover");

    // R4 12-hour transitions
    set_time(1, 0, 11, 59, 59, 10, 1, 1, 10, 20);
    step(0, 1, 0, "R10 load 12h");
    step(1, 0, 0, "R4 11 AM to 12 PM");
    set_time(1, 1, 12, 59, 59, 10, 1, 1, 10, 20);
    step(0, 1, 0, "R10 load 12h");
    step(1, 0, 0, "R4 12 PM to 1 PM");
    set_time(1, 1, 11, 59, 59, 31, 1, 5, 10, 20);
    step(0, 1, 0, "R10 load 12h");
    step(1, 0, 0, "R4 11 PM to 12 AM date advance");

    // R5 R6 February
    set_time(0, 0, 23, 59, 59, 28, 2, 1, 1, 20);
    step(0, 1, 0, "R10 load");
    step(1, 0, 0, "R5 Feb 28 common year");
    set_time(0, 0, 23, 59, 59, 28, 2, 1, 4, 20);
    step(0, 1, 0, "R10 load");
    step(1, 0, 0, "R6 Feb 28 leap year");
    for (int i = 0; i < 86400; i += 1) begin
      if (i < 86399) begin
        tick_i = 1'b1; @(posedge clk); model_tick(); @(negedge clk); tick_i = 1'b0;
      end else step(1, 0, 0, "R6 Feb 29 to Mar 1");
    end
    set_time(0, 0, 23, 59, 59, 28, 2, 1, 0, 20);
    step(0, 1, 0, "R10 load");
    step(1, 0, 0, "R6 year 00 is leap");

    // R7 year and century
    set_time(0, 0, 23, 59, 59, 31, 12, 6, 99, 19);
    step(0, 1, 0, "R10 load");
    step(1, 0, 0, "R7 year 99 to century 20");
    set_time(0, 0, 23, 59, 59, 31, 12, 6, 99, 99);
    step(0, 1, 0, "R10 load");
    step(1, 0, 0, "R7 century 99 wraps");

    // R11 write protect
    set_time(0, 0, 5, 5, 5, 5, 5, 5, 5, 20);
    step(0, 1, 1, "R11 set protect");
    set_time(0, 0, 9, 9, 9, 9, 9, 2, 9, 20);
    step(0, 1, 1, "R11 protected load ignored");
    step(1, 1, 1, "R11 protected load tick advances");
    step(0, 1, 0, "R11 clearing load keeps time");
    step(0, 1, 0, "R11 load after clear");

    // random phase
    for (int i = 0; i < 300; i++) begin
      int mode, pm, h, mi, s, mo, y, d, n;
      mode = $urandom_range(1);
      pm   = $urandom_range(1);
      if (mode != 0) h = ($urandom_range(1) != 0) ? 11 : $urandom_range(12, 1);
      else           h = ($urandom_range(1) != 0) ? 23 : $urandom_range(23);
      mi = ($urandom_range(1) != 0) ? 59 : $urandom_range(59);
      s  = $urandom_range(59, 30);
      mo = ($urandom_range(3) == 0) ? 12 : $urandom_range(12, 1);
      y  = ($urandom_range(3) == 0) ? 99 : $urandom_range(99);
      d  = mlen(mo, y) - $urandom_range(1);
      set_time(mode, pm, h, mi, s, d, mo, $urandom_range(7, 1), y, $urandom_range(99));
      step(0, 1, 0, "R10 random load");
      n = $urandom_range(150);
      for (int j = 0; j < n; j++)
        step($urandom_range(3) != 0, 0, 0, "R2 random run");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule